// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the sixteen 32-bit architectural registers of a RISC core. Their physical storage depends on the 5-bit processor mode. Registers r0–r7 and the program counter r15 exist once. The fast-interrupt mode has its own copies of r8–r14. Four other exception modes each keep private copies of only the stack pointer (r13) and the link register (r14). The privileged system mode sees the plain user registers. The block turns each logical register number into a physical storage slot for the current mode, on two read ports and one write port.

The program counter also has a dedicated read and write path, so fetch logic can advance it without using a general port. Each exception mode has one saved status register, reached through its own read/write port. A user-bank select input lets privileged code read and write the user copies of r8–r14 while the core runs in any other mode. Reads are combinational. Writes land on the rising clock edge. The reset is asynchronous and active-low, and it is released synchronously inside the block.

Top module: `banked_regfile`

## Requirements
- R1: While reset is asserted and after it is released, before any write, every register in every mode, the program counter and every saved status register read as zero.
- R2: Writes take effect at the rising clock edge. A read port that addresses the register being written in the same cycle returns the old value, and the new value the cycle after.
- R3: Logical r0–r7 and r15 refer to the same storage in every mode, and a general read of r15 equals the program-counter output.
- R4: In mode 5'b10001 (fast interrupt), logical r8–r14 use storage private to that mode.
- R5: Modes 5'b10010, 5'b10011, 5'b10111 and 5'b11011 each have private r13 and r14 and share r8–r12 with user mode.
- R6: Mode 5'b11111 (system) uses exactly the registers of mode 5'b10000 (user).
- R7: Any mode value other than the seven listed behaves as user mode for register mapping and for the saved status port.
- R8: The program-counter output always shows r15. A program-counter write updates r15 at the next edge.
- R9: When the general port writes r15 in the same cycle as a program-counter write, the general port's data is stored.
- R10: Each of the five exception modes has its own saved status register, read and written through the status port while in that mode.
- R11: In user or system mode the status port reads zero, and a write to it changes no saved status register.
- R12: With the user-bank select high, logical r8–r14 on all general ports refer to the user-mode copies, whatever the current mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 5 | Current processor mode |
| user_bank | input | 1 | Map r8–r14 to the user copies on general ports |
| ra_addr | input | 4 | Read port A register number |
| ra_data | output | 32 | Read port A data |
| rb_addr | input | 4 | Read port B register number |
| rb_data | output | 32 | Read port B data |
| wr_en | input | 1 | General write enable |
| wr_addr | input | 4 | General write register number |
| wr_data | input | 32 | General write data |
| pc_rdata | output | 32 | Current program counter (r15) |
| pc_we | input | 1 | Program-counter write enable |
| pc_wdata | input | 32 | Program-counter write data |
| psr_rdata | output | 32 | Saved status register of the current mode |
| psr_we | input | 1 | Saved status write enable |
| psr_wdata | input | 32 | Saved status write data |

## Verification
Random traffic picks the mode from all seven valid encodings plus two unlisted values. This separates a mapping bug in one bank from a mapping bug in the shared registers, and shows whether unknown modes fall back to user storage. The user-bank select is raised in a minority of cycles, so cross-bank writes from exception modes must later show up in user mode. Directed sequences cover the remaining cases. One reads a register in the cycle it is written. One has the general port and the program-counter port collide on r15. One writes the status port from user and system modes and then reads back all five exception modes.

// File: rtl/bregs_pkg.sv
`timescale 1ns/1ps
package bregs_pkg;

  typedef enum logic [4:0] {
    MD_USR = 5'b10000,
    MD_FIQ = 5'b10001,
    MD_IRQ = 5'b10010,
    MD_SVC = 5'b10011,
    MD_ABT = 5'b10111,
    MD_UND = 5'b11011,
    MD_SYS = 5'b11111
  } mode_e;

  // Storage bank owning the r13/r14 pair; BK_USR also covers system mode.
  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5
  } bank_e;

  localparam int ADDR_W   = 4;
  localparam int LOW_N    = 8;   // r0..r7, never banked
  localparam int HI_N     = 5;   // r8..r12, banked only by fast interrupt
  localparam int SPLR_N   = 2;   // r13, r14
  localparam int BANK_N   = 6;   // banks owning r13/r14
  localparam int PSR_N    = BANK_N - 1;
  localparam int HI_USR   = LOW_N;
  localparam int HI_FIQ   = LOW_N + HI_N;
  localparam int SPLR_B   = LOW_N + 2 * HI_N;
  localparam int PC_IDX   = SPLR_B + SPLR_N * BANK_N;
  localparam int PHYS_N   = PC_IDX + 1;
  localparam int PIDX_W   = $clog2(PHYS_N);
  localparam int PSEL_W   = $clog2(PSR_N);

  // Logical register number to physical slot for a given bank.
  function automatic logic [PIDX_W-1:0] map_phys(input bank_e bk,
                                                  input logic [ADDR_W-1:0] a);
    int r;
    int ai;
    ai = int'(a);
    if (ai == 15)
      r = PC_IDX;
    else if (ai < LOW_N)
      r = ai;
    else if (ai < LOW_N + HI_N)
      r = ((bk == BK_FIQ) ? HI_FIQ : HI_USR) + (ai - LOW_N);
    else
      r = SPLR_B + SPLR_N * int'(bk) + (ai - LOW_N - HI_N);
    return PIDX_W'(r);
  endfunction

endpackage

// File: rtl/bregs_mode_dec.sv
`timescale 1ns/1ps
module bregs_mode_dec
  import bregs_pkg::*;
(
  input  logic [4:0]        mode,
  input  logic              user_bank,
  output bank_e             gpr_bank,
  output logic              psr_valid,
  output logic [PSEL_W-1:0] psr_sel
);

  bank_e cur_bank;

  always_comb begin
    case (mode)
      MD_FIQ:  cur_bank = BK_FIQ;
      MD_IRQ:  cur_bank = BK_IRQ;
      MD_SVC:  cur_bank = BK_SVC;
      MD_ABT:  cur_bank = BK_ABT;
      MD_UND:  cur_bank = BK_UND;
      default: cur_bank = BK_USR;   // user, system and unlisted codes
    endcase
  end

  always_comb begin
    gpr_bank  = user_bank ? BK_USR : cur_bank;
    psr_valid = (cur_bank != BK_USR);
    psr_sel   = psr_valid ? PSEL_W'(int'(cur_bank) - 1) : '0;
  end

endmodule

// File: rtl/bregs_map.sv
`timescale 1ns/1ps
module bregs_map
  import bregs_pkg::*;
#(
  parameter int NPORTS = 3
) (
  input  bank_e                          bank,
  input  logic [NPORTS-1:0][ADDR_W-1:0]  addr,
  output logic [NPORTS-1:0][PIDX_W-1:0]  idx
);

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    always_comb idx[p] = map_phys(bank, addr[p]);
  end

endmodule

// File: rtl/bregs_store.sv
`timescale 1ns/1ps
module bregs_store
  import bregs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NRD    = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [PIDX_W-1:0]             wr_idx,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic                          pc_we,
  input  logic [DATA_W-1:0]             pc_wdata,
  input  logic [NRD-1:0][PIDX_W-1:0]    rd_idx,
  output logic [NRD-1:0][DATA_W-1:0]    rd_data,
  output logic [DATA_W-1:0]             pc_rdata
);

  logic [DATA_W-1:0] mem_q [PHYS_N];
  logic [DATA_W-1:0] mem_d [PHYS_N];
  logic [PHYS_N-1:0] ent_en;

  // Next state: program-counter port first, general port overrides it.
  always_comb begin
    for (int i = 0; i < PHYS_N; i++) begin
      mem_d[i]  = mem_q[i];
      ent_en[i] = 1'b0;
    end
    if (pc_we) begin
      mem_d[PC_IDX]  = pc_wdata;
      ent_en[PC_IDX] = 1'b1;
    end
    if (wr_en && (int'(wr_idx) < PHYS_N)) begin
      mem_d[wr_idx]  = wr_data;
      ent_en[wr_idx] = 1'b1;
    end
  end

  for (genvar g = 0; g < PHYS_N; g++) begin : g_ent
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= '0;
      else if (ent_en[g])
        q <= mem_d[g];
    end
    assign mem_q[g] = q;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb rd_data[p] = (int'(rd_idx[p]) < PHYS_N) ? mem_q[rd_idx[p]] : '0;
  end

  assign pc_rdata = mem_q[PC_IDX];

endmodule

// File: rtl/bregs_spsr.sv
`timescale 1ns/1ps
module bregs_spsr
  import bregs_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [PSEL_W-1:0] sel,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] sv_q [PSR_N];
  logic [PSR_N-1:0]  sv_en;

  always_comb begin
    for (int i = 0; i < PSR_N; i++)
      sv_en[i] = we && valid && (int'(sel) == i);
  end

  for (genvar g = 0; g < PSR_N; g++) begin : g_sv
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= '0;
      else if (sv_en[g])
        q <= wdata;
    end
    assign sv_q[g] = q;
  end

  always_comb rdata = (valid && int'(sel) < PSR_N) ? sv_q[sel] : '0;

endmodule

// File: rtl/banked_regfile.sv
`timescale 1ns/1ps
module banked_regfile
  import bregs_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        mode,
  input  logic              user_bank,
  input  logic [3:0]        ra_addr,
  output logic [DATA_W-1:0] ra_data,
  input  logic [3:0]        rb_addr,
  output logic [DATA_W-1:0] rb_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] pc_rdata,
  input  logic              pc_we,
  input  logic [DATA_W-1:0] pc_wdata,
  output logic [DATA_W-1:0] psr_rdata,
  input  logic              psr_we,
  input  logic [DATA_W-1:0] psr_wdata
);

  localparam int NRD = 2;
  localparam int NMAP = NRD + 1;

  // Reset: asserted at once, released through two flops.
  logic rst_s1, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_q  <= rst_s1;
    end
  end

  bank_e             gpr_bank;
  logic              psr_valid;
  logic [PSEL_W-1:0] psr_sel;

  bregs_mode_dec u_dec (
    .mode      (mode),
    .user_bank (user_bank),
    .gpr_bank  (gpr_bank),
    .psr_valid (psr_valid),
    .psr_sel   (psr_sel)
  );

  logic [NMAP-1:0][ADDR_W-1:0] map_addr;
  logic [NMAP-1:0][PIDX_W-1:0] map_idx;
  logic [NRD-1:0][PIDX_W-1:0]  rd_idx;
  logic [NRD-1:0][DATA_W-1:0]  rd_data;

  assign map_addr = {wr_addr, rb_addr, ra_addr};

  bregs_map #(.NPORTS(NMAP)) u_map (
    .bank (gpr_bank),
    .addr (map_addr),
    .idx  (map_idx)
  );

  assign rd_idx = {map_idx[1], map_idx[0]};

  bregs_store #(.DATA_W(DATA_W), .NRD(NRD)) u_store (
    .clk      (clk),
    .rst_n    (rst_q),
    .wr_en    (wr_en),
    .wr_idx   (map_idx[2]),
    .wr_data  (wr_data),
    .pc_we    (pc_we),
    .pc_wdata (pc_wdata),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data),
    .pc_rdata (pc_rdata)
  );

  assign ra_data = rd_data[0];
  assign rb_data = rd_data[1];

  bregs_spsr #(.DATA_W(DATA_W)) u_spsr (
    .clk   (clk),
    .rst_n (rst_q),
    .valid (psr_valid),
    .sel   (psr_sel),
    .we    (psr_we),
    .wdata (psr_wdata),
    .rdata (psr_rdata)
  );

endmodule

// File: rtl/bregs_chk.sv
`timescale 1ns/1ps
module bregs_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_q,
  input logic [4:0]        mode,
  input logic              user_bank,
  input logic [3:0]        ra_addr,
  input logic [DATA_W-1:0] ra_data,
  input logic              wr_en,
  input logic [3:0]        wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] pc_rdata,
  input logic              pc_we,
  input logic [DATA_W-1:0] pc_wdata,
  input logic [DATA_W-1:0] psr_rdata,
  input logic              psr_we,
  input logic [DATA_W-1:0] psr_wdata
);

  logic no_psr_mode;
  logic listed_mode;
  assign listed_mode = (mode == 5'b10000) || (mode == 5'b10001) || (mode == 5'b10010) ||
                       (mode == 5'b10011) || (mode == 5'b10111) || (mode == 5'b11011) ||
                       (mode == 5'b11111);
  assign no_psr_mode = (mode == 5'b10000) || (mode == 5'b11111);

  // R2
  write_visible_next_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (wr_en && wr_addr == ra_addr && wr_addr != 4'hF) |=>
      (!($stable(mode) && $stable(user_bank) && $stable(ra_addr)) || ra_data == $past(wr_data)));

  // R3
  r15_matches_pc_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (ra_addr == 4'hF) |-> (ra_data == pc_rdata));

  // R8
  pc_port_write_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (pc_we && !(wr_en && wr_addr == 4'hF)) |=> (pc_rdata == $past(pc_wdata)));

  // R9
  general_wins_pc_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (pc_we && wr_en && wr_addr == 4'hF) |=> (pc_rdata == $past(wr_data)));

  // R10
  psr_write_back_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (psr_we && listed_mode && !no_psr_mode) |=>
      (!$stable(mode) || psr_rdata == $past(psr_wdata)));

  // R11
  psr_zero_plain_chk: assert property (@(posedge clk) disable iff (!rst_q)
    no_psr_mode |-> (psr_rdata == '0));

  // R7
  psr_zero_unlisted_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !listed_mode |-> (psr_rdata == '0));

endmodule

bind banked_regfile bregs_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_q     (rst_q),
  .mode      (mode),
  .user_bank (user_bank),
  .ra_addr   (ra_addr),
  .ra_data   (ra_data),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .pc_rdata  (pc_rdata),
  .pc_we     (pc_we),
  .pc_wdata  (pc_wdata),
  .psr_rdata (psr_rdata),
  .psr_we    (psr_we),
  .psr_wdata (psr_wdata)
);

// File: tb/sim_banked_regfile.sv
`timescale 1ns/1ps
module sim_banked_regfile;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [4:0]   mode;
  logic         user_bank;
  logic [3:0]   ra_addr, rb_addr, wr_addr;
  logic [W-1:0] ra_data, rb_data, wr_data;
  logic         wr_en, pc_we, psr_we;
  logic [W-1:0] pc_rdata, pc_wdata, psr_rdata, psr_wdata;

  always #5 clk = ~clk;

  banked_regfile #(.DATA_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .user_bank(user_bank),
    .ra_addr(ra_addr), .ra_data(ra_data), .rb_addr(rb_addr), .rb_data(rb_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pc_rdata(pc_rdata), .pc_we(pc_we), .pc_wdata(pc_wdata),
    .psr_rdata(psr_rdata), .psr_we(psr_we), .psr_wdata(psr_wdata)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference model: user view, fast-interrupt r8..r14, r13/r14 of four modes.
  logic [W-1:0] m_usr [16];
  logic [W-1:0] m_fiq [7];
  logic [W-1:0] m_sp  [4][2];
  logic [W-1:0] m_psr [5];
  logic [W-1:0] m_pc;

  function automatic int kind_of(input logic [4:0] md);
    case (md)
      5'b10001: return 1;
      5'b10010: return 2;
      5'b10011: return 3;
      5'b10111: return 4;
      5'b11011: return 5;
      default:  return 0;
    endcase
  endfunction

  function automatic logic [W-1:0] ref_rd(input logic [4:0] md, input logic ub,
                                          input logic [3:0] a);
    int k;
    k = ub ? 0 : kind_of(md);
    if (a == 4'hF) return m_pc;
    if (k == 1 && a >= 8) return m_fiq[a - 8];
    if (k >= 2 && a >= 13) return m_sp[k - 2][a - 13];
    return m_usr[a];
  endfunction

  function automatic logic [W-1:0] ref_psr(input logic [4:0] md);
    int k;
    k = kind_of(md);
    return (k >= 1) ? m_psr[k - 1] : '0;
  endfunction

  function automatic string tag_for(input logic [4:0] md, input logic ub,
                                    input logic [3:0] a);
    int k;
    k = kind_of(md);
    if (a < 8 || a == 4'hF) return "R3";
    if (ub) return "R12";
    if (md == 5'b11111) return "R6";
    if (k == 0 && md != 5'b10000) return "R7";
    if (k == 1) return "R4";
    if (k >= 2) return "R5";
    return "R2";
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic check_reads(input string tag_override);
    string ta, tb, tp;
    #1;
    ta = (tag_override != "") ? tag_override : tag_for(mode, user_bank, ra_addr);
    tb = (tag_override != "") ? tag_override : tag_for(mode, user_bank, rb_addr);
    tp = (kind_of(mode) >= 1) ? "R10" : ((mode == 5'b10000 || mode == 5'b11111) ? "R11" : "R7");
    if (tag_override != "") tp = tag_override;
    check(ta, "port A", ra_data, ref_rd(mode, user_bank, ra_addr));
    check(tb, "port B", rb_data, ref_rd(mode, user_bank, rb_addr));
    check((tag_override != "") ? tag_override : "R8", "pc", pc_rdata, m_pc);
    check(tp, "psr", psr_rdata, ref_psr(mode));
  endtask

  // Apply this cycle's writes to the model (they land at the coming edge).
  task automatic commit();
    int k;
    k = user_bank ? 0 : kind_of(mode);
    if (psr_we && kind_of(mode) >= 1) m_psr[kind_of(mode) - 1] = psr_wdata;
    if (pc_we) m_pc = pc_wdata;
    if (wr_en) begin
      if (wr_addr == 4'hF) m_pc = wr_data;
      else if (k == 1 && wr_addr >= 8) m_fiq[wr_addr - 8] = wr_data;
      else if (k >= 2 && wr_addr >= 13) m_sp[k - 2][wr_addr - 13] = wr_data;
      else m_usr[wr_addr] = wr_data;
    end
  endtask

  task automatic cycle(input string tag_override);
    check_reads(tag_override);
    commit();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    wr_en = 0; pc_we = 0; psr_we = 0;
    wr_addr = 0; wr_data = 0; pc_wdata = 0; psr_wdata = 0;
    user_bank = 0; ra_addr = 0; rb_addr = 0;
  endtask

  task automatic wr(input logic [4:0] md, input logic ub, input logic [3:0] a,
                    input logic [W-1:0] d, input string tag);
    idle(); mode = md; user_bank = ub; wr_en = 1; wr_addr = a; wr_data = d;
    ra_addr = a; rb_addr = a;
    cycle(tag);
  endtask

  task automatic rd(input logic [4:0] md, input logic ub, input logic [3:0] a,
                    input string tag);
    idle(); mode = md; user_bank = ub; ra_addr = a; rb_addr = 4'hF - a;
    cycle(tag);
  endtask

  function automatic logic [4:0] pick_mode(input int r);
    case (r % 9)
      0: return 5'b10000;
      1: return 5'b10001;
      2: return 5'b10010;
      3: return 5'b10011;
      4: return 5'b10111;
      5: return 5'b11011;
      6: return 5'b11111;
      7: return 5'b00101;
      default: return 5'b11010;
    endcase
  endfunction

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [4:0] modes [7];
    void'($urandom(32'd20240611));
    modes = '{5'b10000, 5'b10001, 5'b10010, 5'b10011, 5'b10111, 5'b11011, 5'b11111};
    for (int i = 0; i < 16; i++) m_usr[i] = '0;
    for (int i = 0; i < 7; i++) m_fiq[i] = '0;
    for (int i = 0; i < 4; i++) begin m_sp[i][0] = '0; m_sp[i][1] = '0; end
    for (int i = 0; i < 5; i++) m_psr[i] = '0;
    m_pc = '0;

    rst_n = 0; mode = 5'b10000; idle();
    repeat (3) @(negedge clk);
    // R1: zero while held in reset
    check_reads("R1");
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1: every register of every mode reads zero after release
    for (int m = 0; m < 7; m++)
      for (int a = 0; a < 16; a++) rd(modes[m], 1'b0, 4'(a), "R1");

    // R2: same-cycle read returns old value, next cycle new
    wr(5'b10000, 0, 4'd5, 32'hA5A5_0005, "R2");
    rd(5'b10000, 0, 4'd5, "R2");

    // R4 / R6: user vs fast-interrupt r8..r14, system equals user
    for (int a = 8; a < 15; a++) wr(5'b10000, 0, 4'(a), 32'h1000_0000 + 32'(a), "R6");
    for (int a = 8; a < 15; a++) wr(5'b10001, 0, 4'(a), 32'h2000_0000 + 32'(a), "R4");
    for (int a = 8; a < 15; a++) rd(5'b11111, 0, 4'(a), "R6");
    for (int a = 8; a < 15; a++) rd(5'b10001, 0, 4'(a), "R4");

    // R5: private r13/r14 per mode, shared r12
    for (int m = 2; m < 6; m++) begin
      wr(modes[m], 0, 4'd13, 32'h3000_0000 + 32'(m), "R5");
      wr(modes[m], 0, 4'd14, 32'h4000_0000 + 32'(m), "R5");
    end
    for (int m = 0; m < 7; m++) begin
      rd(modes[m], 0, 4'd13, "R5");
      rd(modes[m], 0, 4'd12, "R5");
    end

    // R7: unlisted mode uses user storage
    rd(5'b00101, 0, 4'd13, "R7");
    wr(5'b01100, 0, 4'd14, 32'h7777_0014, "R7");
    rd(5'b10000, 0, 4'd14, "R7");

    // R12: user bank reached from exception modes
    wr(5'b10001, 1, 4'd9, 32'hC0DE_0009, "R12");
    wr(5'b10011, 1, 4'd13, 32'hC0DE_000D, "R12");
    rd(5'b10000, 0, 4'd9, "R12");
    rd(5'b10000, 0, 4'd13, "R12");
    rd(5'b10011, 0, 4'd13, "R12");

    // R8: program-counter port
    idle(); mode = 5'b10010; pc_we = 1; pc_wdata = 32'h0000_8000; ra_addr = 4'hF;
    cycle("R8");
    rd(5'b10010, 0, 4'hF, "R8");

    // R9: general write to r15 beats program-counter write
    idle(); mode = 5'b10000; pc_we = 1; pc_wdata = 32'h1111_1111;
    wr_en = 1; wr_addr = 4'hF; wr_data = 32'h2222_2222;
    cycle("R9");
    rd(5'b10000, 0, 4'hF, "R9");

    // R10: per-mode saved status
    for (int m = 1; m < 6; m++) begin
      idle(); mode = modes[m]; psr_we = 1; psr_wdata = 32'h5000_0000 + 32'(m);
      cycle("R10");
    end
    for (int m = 1; m < 6; m++) rd(modes[m], 0, 4'd0, "R10");

    // R11: status writes ignored in user and system modes
    idle(); mode = 5'b10000; psr_we = 1; psr_wdata = 32'hDEAD_BEEF; cycle("R11");
    idle(); mode = 5'b11111; psr_we = 1; psr_wdata = 32'hFEED_FACE; cycle("R11");
    for (int m = 0; m < 7; m++) rd(modes[m], 0, 4'd1, "R11");

    // Random traffic
    for (int i = 0; i < 1500; i++) begin
      idle();
      mode      = pick_mode(int'($urandom % 1000));
      user_bank = ($urandom % 8) == 0;
      ra_addr   = 4'($urandom);
      rb_addr   = 4'($urandom);
      wr_en     = ($urandom % 3) != 0;
      wr_addr   = ($urandom % 2) ? 4'(8 + $urandom % 7) : 4'($urandom);
      wr_data   = $urandom;
      pc_we     = ($urandom % 4) == 0;
      pc_wdata  = $urandom;
      psr_we    = ($urandom % 4) == 0;
      psr_wdata = $urandom;
      cycle("");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule